// File: doc/BRIEF.md
# Input Event Counter Bank

This block keeps one 16-bit up counter for each of eight isolated digital inputs. Each input is first brought into the clock domain through a short flip-flop chain. Its edges are then detected, and the counter of that channel advances on either rising or falling edges, as selected per channel. A counter that has reached its ceiling wraps to a programmable preset instead of to zero. Two sticky per-channel flags record wrap events and match events. Each flag can only be set while its own enable bit is on.

A mailbox controller drives the block through two command channels. The first is a mask command, which applies an 8-bit channel mask to an operation: run enables, edge polarity, overflow enable, match enable, reload to preset, or clearing flags. The second is a value load, which writes one channel's preset or match value. A combinational read port returns the current count of any channel. A single interrupt line is the OR of every flag.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every count reads 0x0000, all channels are stopped, all flags and `irq` are 0, every preset is 0x0000, every match value is 0x8000, and every channel counts rising edges.
- R2: A running channel advances by exactly one for each selected edge on its input. The input passes two synchroniser flops and one history flop, so an edge applied before clock edge k changes the count at clock edge k+2.
- R3: Command op 2 writes the edge mask. A mask bit of 0 selects rising edges for that channel and a bit of 1 selects falling edges.
- R4: Command op 0 writes the run mask. A channel whose bit is 1 counts. A channel whose bit is 0 holds its value whatever its input does.
- R5: Command op 1 reloads every channel selected in the mask with that channel's stored preset on the next clock edge. Unselected channels are unaffected.
- R6: When a reload (op 1) and a counting edge fall on the same channel in the same cycle, the reload wins. That cycle sets no flag for the channel.
- R7: A value load with `ld_sel`=0 writes the preset of channel `ld_chan`, and `ld_sel`=1 writes its match value. A load takes effect for commands and counting from the next cycle onward.
- R8: A step taken at 0xFFFF wraps the count to the channel's preset. If the channel's bit in the overflow-enable mask (op 3) is 1, the step also sets that channel's overflow flag. If the bit is 0, no flag is set.
- R9: A step whose resulting count equals the channel's match value sets the match flag if the channel's bit in the match-enable mask (op 4) is 1. If the bit is 0, no flag is set.
- R10: Flags stay set until cleared. Op 5 clears the overflow flags of the masked channels and op 6 clears their match flags. A flag set in the same cycle as its clear remains set.
- R11: `irq` is 1 exactly when any overflow or match flag is set.
- R12: `rd_value` shows the current count of channel `rd_chan` in the same cycle, with no added delay.
- R13: Command op 7 changes no count, flag, mask or stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 8 | Asynchronous event inputs, one per channel |
| cmd_valid | input | 1 | Mask command strobe |
| cmd_op | input | 3 | Mask command operation code |
| cmd_mask | input | 8 | Channel mask for the command |
| ld_valid | input | 1 | Value load strobe |
| ld_sel | input | 1 | 0 writes the preset, 1 writes the match value |
| ld_chan | input | 3 | Channel targeted by the load |
| ld_value | input | 16 | Value to store |
| rd_chan | input | 3 | Channel selected for reading |
| rd_value | output | 16 | Current count of the selected channel |
| ovf_flag | output | 8 | Sticky overflow flags |
| match_flag | output | 8 | Sticky match flags |
| irq | output | 1 | OR of all flags |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a reload command and a counting edge on the same channel. The second is a flag being set and a clear command aimed at it. The bench provokes the first pair by toggling an input every cycle while it holds a reload command. It provokes the second by issuing clears while a wrap or match step is in flight. A behavioural model, which applies reload-over-step and set-over-clear, is compared with every count and flag on every clock. Explicit checks confirm that the count sits at the preset while the collisions persist.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   typedef enum logic [2:0] {
      OP_RUN       = 3'd0,
      OP_RELOAD    = 3'd1,
      OP_EDGE      = 3'd2,
      OP_OVF_EN    = 3'd3,
      OP_MATCH_EN  = 3'd4,
      OP_CLR_OVF   = 3'd5,
      OP_CLR_MATCH = 3'd6,
      OP_NONE      = 3'd7
   } evcnt_op_e;
endpackage

// File: rtl/evcnt_sync.sv
module evcnt_sync #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] stg_q [DEPTH];
   logic [W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) stg_q[k] <= '0;
         hist_q <= '0;
      end else begin
         stg_q[0] <= din;
         for (int k = 1; k < DEPTH; k++) stg_q[k] <= stg_q[k-1];
         hist_q <= stg_q[DEPTH-1];
      end
   end

   assign rise = stg_q[DEPTH-1] & ~hist_q;
   assign fall = ~stg_q[DEPTH-1] & hist_q;
endmodule

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
   import evcnt_pkg::*;
#(
   parameter int          NCH         = 8,
   parameter int          CW          = 16,
   parameter logic [CW-1:0] PRESET_INIT = '0,
   parameter logic [CW-1:0] MATCH_INIT  = '0,
   localparam int         CHW         = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [2:0]               cmd_op,
   input  logic [NCH-1:0]           cmd_mask,
   input  logic                     ld_valid,
   input  logic                     ld_sel,
   input  logic [CHW-1:0]           ld_chan,
   input  logic [CW-1:0]            ld_value,
   output logic [NCH-1:0]           run_q,
   output logic [NCH-1:0]           edge_q,
   output logic [NCH-1:0]           ovf_en_q,
   output logic [NCH-1:0]           match_en_q,
   output logic [NCH-1:0][CW-1:0]   preset_q,
   output logic [NCH-1:0][CW-1:0]   match_q,
   output logic [NCH-1:0]           reload,
   output logic [NCH-1:0]           clr_ovf,
   output logic [NCH-1:0]           clr_match
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q      <= '0;
         edge_q     <= '0;
         ovf_en_q   <= '0;
         match_en_q <= '0;
         for (int i = 0; i < NCH; i++) begin
            preset_q[i] <= PRESET_INIT;
            match_q[i]  <= MATCH_INIT;
         end
      end else begin
         if (cmd_valid) begin
            case (cmd_op)
               OP_RUN:      run_q      <= cmd_mask;
               OP_EDGE:     edge_q     <= cmd_mask;
               OP_OVF_EN:   ovf_en_q   <= cmd_mask;
               OP_MATCH_EN: match_en_q <= cmd_mask;
               default: ;
            endcase
         end
         if (ld_valid) begin
            for (int i = 0; i < NCH; i++) begin
               if (ld_chan == CHW'(i)) begin
                  if (ld_sel) match_q[i]  <= ld_value;
                  else        preset_q[i] <= ld_value;
               end
            end
         end
      end
   end

   assign reload    = (cmd_valid && cmd_op == OP_RELOAD)    ? cmd_mask : '0;
   assign clr_ovf   = (cmd_valid && cmd_op == OP_CLR_OVF)   ? cmd_mask : '0;
   assign clr_match = (cmd_valid && cmd_op == OP_CLR_MATCH) ? cmd_mask : '0;
endmodule

// File: rtl/evcnt_chan.sv
module evcnt_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          reload,
   input  logic [CW-1:0] preset,
   input  logic [CW-1:0] match,
   input  logic          ovf_en,
   input  logic          match_en,
   input  logic          clr_ovf,
   input  logic          clr_match,
   output logic [CW-1:0] count,
   output logic          ovf_flag,
   output logic          match_flag
);
   logic          at_top;
   logic          advance;
   logic [CW-1:0] next_val;
   logic          set_ovf;
   logic          set_match;

   assign at_top    = (count == {CW{1'b1}});
   assign advance   = step && !reload;
   assign next_val  = at_top ? preset : count + 1'b1;
   assign set_ovf   = advance && at_top && ovf_en;
   assign set_match = advance && (next_val == match) && match_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count      <= '0;
         ovf_flag   <= 1'b0;
         match_flag <= 1'b0;
      end else begin
         if (reload)       count <= preset;
         else if (advance) count <= next_val;
         ovf_flag   <= (ovf_flag & ~clr_ovf) | set_ovf;
         match_flag <= (match_flag & ~clr_match) | set_match;
      end
   end
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
   import evcnt_pkg::*;
#(
   parameter int NCH        = 8,
   parameter int CW         = 16,
   parameter int SYNC_DEPTH = 2,
   parameter logic [CW-1:0] PRESET_INIT = '0,
   parameter logic [CW-1:0] MATCH_INIT  = CW'(1) << (CW - 1),
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   evt_in,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [NCH-1:0]   cmd_mask,
   input  logic             ld_valid,
   input  logic             ld_sel,
   input  logic [CHW-1:0]   ld_chan,
   input  logic [CW-1:0]    ld_value,
   input  logic [CHW-1:0]   rd_chan,
   output logic [CW-1:0]    rd_value,
   output logic [NCH-1:0]   ovf_flag,
   output logic [NCH-1:0]   match_flag,
   output logic             irq
);
   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("evcnt_bank: NCH must lie in 1..32");
   end
   if (CW < 2) begin : g_bad_cw
      $error("evcnt_bank: CW must be at least 2");
   end
   if (SYNC_DEPTH < 2) begin : g_bad_sync
      $error("evcnt_bank: SYNC_DEPTH must be at least 2");
   end

   logic [NCH-1:0]         rise, fall;
   logic [NCH-1:0]         run_q, edge_q, ovf_en_q, match_en_q;
   logic [NCH-1:0][CW-1:0] preset_q, match_q, cnt_q;
   logic [NCH-1:0]         reload, clr_ovf, clr_match, step;

   evcnt_sync #(.W(NCH), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (evt_in),
      .rise (rise),
      .fall (fall)
   );

   evcnt_ctrl #(
      .NCH(NCH), .CW(CW), .PRESET_INIT(PRESET_INIT), .MATCH_INIT(MATCH_INIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_mask  (cmd_mask),
      .ld_valid  (ld_valid),
      .ld_sel    (ld_sel),
      .ld_chan   (ld_chan),
      .ld_value  (ld_value),
      .run_q     (run_q),
      .edge_q    (edge_q),
      .ovf_en_q  (ovf_en_q),
      .match_en_q(match_en_q),
      .preset_q  (preset_q),
      .match_q   (match_q),
      .reload    (reload),
      .clr_ovf   (clr_ovf),
      .clr_match (clr_match)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      assign step[i] = run_q[i] && (edge_q[i] ? fall[i] : rise[i]);

      evcnt_chan #(.CW(CW)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (step[i]),
         .reload    (reload[i]),
         .preset    (preset_q[i]),
         .match     (match_q[i]),
         .ovf_en    (ovf_en_q[i]),
         .match_en  (match_en_q[i]),
         .clr_ovf   (clr_ovf[i]),
         .clr_match (clr_match[i]),
         .count     (cnt_q[i]),
         .ovf_flag  (ovf_flag[i]),
         .match_flag(match_flag[i])
      );
   end

   always_comb begin
      rd_value = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_chan == CHW'(i)) rd_value = cnt_q[i];
      end
   end

   assign irq = |{ovf_flag, match_flag};
endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk #(
   parameter int NCH = 8,
   parameter int CW  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_valid,
   input logic [2:0]             cmd_op,
   input logic [NCH-1:0]         cmd_mask,
   input logic [NCH-1:0][CW-1:0] cnt_q,
   input logic [NCH-1:0][CW-1:0] preset_q,
   input logic [NCH-1:0]         run_q,
   input logic [NCH-1:0]         ovf_en_q,
   input logic [NCH-1:0]         match_en_q,
   input logic [NCH-1:0]         ovf_flag,
   input logic [NCH-1:0]         match_flag
);
   logic [NCH-1:0] rl_hit, co_hit, cm_hit;
   assign rl_hit = (cmd_valid && cmd_op == 3'd1) ? cmd_mask : '0;
   assign co_hit = (cmd_valid && cmd_op == 3'd5) ? cmd_mask : '0;
   assign cm_hit = (cmd_valid && cmd_op == 3'd6) ? cmd_mask : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
         rl_hit[i] |=> cnt_q[i] == $past(preset_q[i]));

      assert_reload_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rl_hit[i] && !ovf_flag[i] && !match_flag[i] |=> !ovf_flag[i] && !match_flag[i]);

      assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !run_q[i] && !rl_hit[i] |=> $stable(cnt_q[i]));

      assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
         run_q[i] && !rl_hit[i] && cnt_q[i] != {CW{1'b1}} |=>
            (cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(cnt_q[i]) + 1'b1));

      assert_wrap_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
         run_q[i] && !rl_hit[i] && cnt_q[i] == {CW{1'b1}} |=>
            (cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(preset_q[i])));

      assert_ovf_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !ovf_en_q[i] && !ovf_flag[i] |=> !ovf_flag[i]);

      assert_match_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !match_en_q[i] && !match_flag[i] |=> !match_flag[i]);

      assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_flag[i] && !co_hit[i] |=> ovf_flag[i]);

      assert_match_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
         match_flag[i] && !cm_hit[i] |=> match_flag[i]);
   end
endmodule

bind evcnt_bank evcnt_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_mask  (cmd_mask),
   .cnt_q     (cnt_q),
   .preset_q  (preset_q),
   .run_q     (run_q),
   .ovf_en_q  (ovf_en_q),
   .match_en_q(match_en_q),
   .ovf_flag  (ovf_flag),
   .match_flag(match_flag)
);

// File: tb/test_evcnt_bank.sv
`timescale 1ns/1ps
module test_evcnt_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_in = '0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [7:0]  cmd_mask = '0;
   logic        ld_valid = 1'b0;
   logic        ld_sel = 1'b0;
   logic [2:0]  ld_chan = '0;
   logic [15:0] ld_value = '0;
   logic [2:0]  rd_chan = '0;
   logic [15:0] rd_value;
   logic [7:0]  ovf_flag, match_flag;
   logic        irq;

   int errors = 0;
   int checks = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   evcnt_bank i_evcnt_bank (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mask(cmd_mask),
      .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_chan(ld_chan), .ld_value(ld_value),
      .rd_chan(rd_chan), .rd_value(rd_value),
      .ovf_flag(ovf_flag), .match_flag(match_flag), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   int         m_cnt [8];
   int         m_pre [8];
   int         m_mt  [8];
   logic [7:0] m_run, m_edg, m_oen, m_men, m_ovf, m_mf;
   logic [7:0] m_s1, m_s2, m_s3;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_cnt[i] = 0; m_pre[i] = 0; m_mt[i] = 32768;
         end
         m_run = 0; m_edg = 0; m_oen = 0; m_men = 0; m_ovf = 0; m_mf = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         int         ncnt [8];
         logic [7:0] nov, nmf;
         nov = m_ovf; nmf = m_mf;
         for (int i = 0; i < 8; i++) begin
            bit hit, rl, setov, setm;
            hit = m_edg[i] ? (!m_s2[i] && m_s3[i]) : (m_s2[i] && !m_s3[i]);
            hit = hit && m_run[i];
            rl  = cmd_valid && cmd_op == 3'd1 && cmd_mask[i];
            setov = 0; setm = 0;
            ncnt[i] = m_cnt[i];
            if (rl) ncnt[i] = m_pre[i];
            else if (hit) begin
               if (m_cnt[i] == 65535) begin
                  ncnt[i] = m_pre[i];
                  setov = m_oen[i];
               end else ncnt[i] = m_cnt[i] + 1;
               setm = m_men[i] && (ncnt[i] == m_mt[i]);
            end
            if (cmd_valid && cmd_op == 3'd5 && cmd_mask[i]) nov[i] = 0;
            if (cmd_valid && cmd_op == 3'd6 && cmd_mask[i]) nmf[i] = 0;
            if (setov) nov[i] = 1;
            if (setm)  nmf[i] = 1;
         end
         for (int i = 0; i < 8; i++) m_cnt[i] = ncnt[i];
         m_ovf = nov; m_mf = nmf;
         if (cmd_valid) begin
            case (cmd_op)
               3'd0: m_run = cmd_mask;
               3'd2: m_edg = cmd_mask;
               3'd3: m_oen = cmd_mask;
               3'd4: m_men = cmd_mask;
               default: ;
            endcase
         end
         if (ld_valid) begin
            if (ld_sel) m_mt[ld_chan] = ld_value;
            else        m_pre[ld_chan] = ld_value;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the model (R11, R12 and the active phase)
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 8; c++) begin
            rd_chan = 3'(c);
            #0.05;
            chk({phase, "/R12"}, $sformatf("count ch%0d", c), int'(rd_value), m_cnt[c]);
         end
         chk(phase, "ovf_flag", int'(ovf_flag), int'(m_ovf));
         chk(phase, "match_flag", int'(match_flag), int'(m_mf));
         chk("R11", "irq", int'(irq), int'(|{m_ovf, m_mf}));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cmd(input logic [2:0] op, input logic [7:0] mask);
      @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_mask = mask;
      @(negedge clk);
      cmd_valid = 0;
   endtask

   task automatic load(input logic sel, input logic [2:0] ch, input logic [15:0] v);
      @(negedge clk);
      ld_valid = 1; ld_sel = sel; ld_chan = ch; ld_value = v;
      @(negedge clk);
      ld_valid = 0;
   endtask

   task automatic pulse(input logic [7:0] mask, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); evt_in = evt_in | mask;
         repeat (2) @(negedge clk);
         evt_in = evt_in & ~mask;
         repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic peek(input logic [2:0] ch, output int v);
      @(posedge clk); #1;
      rd_chan = ch; #0.2;
      v = int'(rd_value);
   endtask

   task automatic wander(input int n);
      logic [7:0] lf = 8'h5B;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         evt_in = lf;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired in phase %s actual=running expected=done", phase);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, v2;
      logic [7:0] f1, f2;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      peek(3'd5, v);
      chk("R1", "count after reset", v, 0);
      chk("R1", "flags after reset", int'({ovf_flag, match_flag}), 0);
      chk("R1", "irq after reset", int'(irq), 0);
      phase = "R4";
      wander(20);                 // stopped counters ignore inputs
      peek(3'd2, v);
      chk("R4", "stopped channel", v, 0);

      phase = "R2";
      cmd(3'd0, 8'hFF);           // op 0: run all
      wander(60);
      evt_in = 0; repeat (4) @(negedge clk);
      pulse(8'h01, 3);
      peek(3'd0, v);
      cmd(3'd1, 8'h01);           // op 1 reload ch0 -> preset 0 (R1 default preset)
      peek(3'd0, v2);
      chk("R1", "default preset via reload", v2, 0);
      pulse(8'h01, 4);
      peek(3'd0, v);
      chk("R2", "four rising edges", v, 4);

      phase = "R3";
      cmd(3'd2, 8'hAA);           // op 2: odd channels count falling
      wander(60);
      evt_in = 0; repeat (4) @(negedge clk);
      cmd(3'd1, 8'h03);
      @(negedge clk); evt_in = 8'h03; repeat (4) @(negedge clk);
      peek(3'd0, v); peek(3'd1, v2);
      chk("R3", "rising on ch0", v, 1);
      chk("R3", "no count on ch1 rising", v2, 0);
      @(negedge clk); evt_in = 8'h00; repeat (4) @(negedge clk);
      peek(3'd1, v2);
      chk("R3", "falling on ch1", v2, 1);
      cmd(3'd2, 8'h00);

      phase = "R4";
      cmd(3'd0, 8'h0F);
      peek(3'd6, v);
      wander(50);
      peek(3'd6, v2);
      chk("R4", "disabled ch6 holds", v2, v);
      evt_in = 0; repeat (4) @(negedge clk);

      phase = "R5";
      load(1'b0, 3'd3, 16'h1234);
      peek(3'd2, v);
      cmd(3'd1, 8'h08);
      peek(3'd3, v2);
      chk("R5", "reload ch3", v2, 16'h1234);
      peek(3'd2, v2);
      chk("R5", "unselected ch2 unchanged", v2, v);

      phase = "R6";
      load(1'b0, 3'd3, 16'd5);
      cmd(3'd0, 8'h08);
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd1; cmd_mask = 8'h08;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk); evt_in[3] = ~evt_in[3];
      end
      peek(3'd3, v);
      chk("R6", "reload beats edge", v, 5);
      @(negedge clk); cmd_valid = 0; evt_in = 0;
      repeat (4) @(negedge clk);

      phase = "R8";
      cmd(3'd5, 8'hFF); cmd(3'd6, 8'hFF);
      cmd(3'd3, 8'h02);           // op 3: overflow enable ch1 only
      load(1'b0, 3'd1, 16'hFFFD);
      load(1'b0, 3'd2, 16'hFFFF);
      cmd(3'd1, 8'h06);
      cmd(3'd0, 8'h06);
      pulse(8'h06, 3);
      peek(3'd1, v);
      chk("R8", "ch1 wrapped to preset", v, 16'hFFFD);
      peek(3'd2, v);
      chk("R8", "ch2 wrapped to preset", v, 16'hFFFF);
      chk("R8", "only ch1 overflow flag", int'(ovf_flag), 8'h02);

      phase = "R9";
      load(1'b0, 3'd0, 16'h7FFE);   // default match 0x8000 (R1)
      load(1'b0, 3'd4, 16'h0000);
      load(1'b1, 3'd4, 16'd3);      // R7 match load
      cmd(3'd4, 8'h11);
      cmd(3'd1, 8'h11);
      cmd(3'd0, 8'h11);
      pulse(8'h11, 2);
      chk("R9", "ch0 match at default 0x8000", int'(match_flag[0]), 1);
      chk("R7", "ch4 not yet at loaded match", int'(match_flag[4]), 0);
      pulse(8'h11, 1);
      chk("R7", "ch4 match at loaded value", int'(match_flag[4]), 1);
      chk("R10", "ch0 flag sticky", int'(match_flag[0]), 1);
      chk("R11", "irq high with flags", int'(irq), 1);

      phase = "R13";
      f1 = match_flag; peek(3'd0, v);
      cmd(3'd7, 8'hFF);
      f2 = match_flag; peek(3'd0, v2);
      chk("R13", "flags after op 7", int'(f2), int'(f1));
      chk("R13", "count after op 7", v2, v);

      phase = "R10";
      cmd(3'd6, 8'h01);
      chk("R10", "ch0 match cleared", int'(match_flag), 8'h10);
      cmd(3'd5, 8'h02);
      cmd(3'd6, 8'h10);
      chk("R10", "all cleared", int'({ovf_flag, match_flag}), 0);
      chk("R11", "irq low after clear", int'(irq), 0);

      // collision hammer: reloads, clears and edges mixed
      phase = "R6";
      cmd(3'd0, 8'hFF); cmd(3'd3, 8'hFF); cmd(3'd4, 8'hFF);
      for (int k = 0; k < 8; k++) load(1'b0, 3'(k), 16'hFFF0 + 16'(k));
      cmd(3'd1, 8'hFF);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         evt_in = evt_in ^ 8'(k * 37 + 11);
         cmd_valid = (k % 3) != 2;
         cmd_op = (k % 4 == 0) ? 3'd1 : ((k % 4 == 1) ? 3'd5 : 3'd6);
         cmd_mask = 8'(k * 53 + 7);
      end
      @(negedge clk); cmd_valid = 0; evt_in = 0;
      repeat (8) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule